// File: doc/BRIEF.md
# Hardware-Limit Timer with Capture

This block is an up-counter whose start, clear and stop actions are each selected from a small set of triggers. The triggers are edges or levels of one external control input, a match of the count against a period value, or a start event. A software enable gates the whole timer. A polarity input swaps the active sense of the external control. The swap applies to single-edge and level triggers, but not to the either-edge triggers.

The external control input is first passed through a synchronizer. An edge is recognised by comparing the synchronized value with its value one clock earlier. A change at the pin therefore acts at the third rising clock edge after it is driven. A period match is registered when the counter reaches the period value. Any match-driven clear or stop then acts on the following clock, so a match-cleared count runs 0 to period, which is period+1 states.

Every stop event loads the count into a capture register and pulses a one-cycle strobe. When the stop trigger is disabled, the active edge of the control input still captures, but the timer keeps running. A clear that comes from the inactive level of the control input also drops the run status and the level output for as long as it lasts. A clear that comes from a match or from a start leaves them high.

Top module: `hlt_timer`

## Requirements
- R1: After synchronous reset, count, cap_val, running, lvl_out and cap_stb are all zero.
- R2: start_sel=0 (free) runs the timer whenever en is 1: running rises one clock after en rises, and count then advances by one per clock. Clearing en drops running on the next clock and holds count unchanged.
- R3: start_sel=2 (single edge) starts on a rising ers_in edge when inv_pol=0 and on a falling edge when inv_pol=1. The opposite edge has no effect. The start shows on running at the third clock edge after ers_in changes.
- R4: start_sel=3 (level) starts while ers_in is at its active level (high for inv_pol=0). With clr_sel=1, the inactive level clears count to 0 and holds running and lvl_out low.
- R5: clr_sel=3 (match) clears count to 0 on the clock after count equals period, giving the sequence 0..period repeating, with running staying 1.
- R6: halt_sel=3 (match stop) stops the timer on the clock after count equals period. It loads cap_val with period and raises cap_stb for exactly that one cycle, and count holds.
- R7: start_sel=1 with halt_sel=1 (either edge) alternates start and stop on successive ers_in transitions. With clr_sel=2, each start clears count to 0. Each stop captures the running count.
- R8: halt_sel=0 never stops the timer, but the active ers_in edge (rising for inv_pol=0, falling for inv_pol=1) still loads cap_val and pulses cap_stb.
- R9: When a stop edge and a match clear fall in the same cycle, cap_val receives the count before the clear, count becomes 0 and running drops.
- R10: lvl_out always equals running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ers_in | input | 1 | External start/clear/stop control, asynchronous |
| en | input | 1 | Software enable |
| inv_pol | input | 1 | Inverts the active sense of ers_in for single-edge and level triggers |
| start_sel | input | 2 | Start trigger: 0 free, 1 either edge, 2 active edge, 3 active level |
| clr_sel | input | 2 | Clear trigger: 0 none, 1 inactive level or match, 2 start or match, 3 match |
| halt_sel | input | 2 | Stop trigger: 0 none (capture on active edge), 1 either edge, 2 active edge, 3 match |
| period | input | CW | Period value compared against count |
| count | output | CW | Current count |
| running | output | 1 | Run status |
| lvl_out | output | 1 | Level output, follows run status |
| cap_val | output | CW | Captured count |
| cap_stb | output | 1 | One-cycle pulse when cap_val loads |

## Verification
Two functions can fall in the same clock: a stop edge from ers_in and a registered period match that clears the counter. The bench provokes this by dropping ers_in five clocks after the start edge, with period 4. The synchronized falling edge is then decoded in the very cycle that the match flag is high. The result passes only if cap_val holds the count from before the clear (4), count returns to 0 and running falls, all on the same clock. The either-edge toggle case is a second collision of the same kind: one edge is both a potential start and a potential stop, and it must stop a running timer and start an idle one.

// File: rtl/hlt_pkg.sv
package hlt_pkg;

    typedef enum logic [1:0] {
        ST_FREE  = 2'd0,
        ST_ANY   = 2'd1,
        ST_EDGE  = 2'd2,
        ST_LEVEL = 2'd3
    } start_mode_e;

    typedef enum logic [1:0] {
        CL_NONE  = 2'd0,
        CL_LVL   = 2'd1,
        CL_START = 2'd2,
        CL_MATCH = 2'd3
    } clr_mode_e;

    typedef enum logic [1:0] {
        HL_NONE  = 2'd0,
        HL_ANY   = 2'd1,
        HL_EDGE  = 2'd2,
        HL_MATCH = 2'd3
    } halt_mode_e;

    typedef struct packed {
        logic rise;
        logic fall;
        logic lvl;
    } ers_ev_t;

endpackage

// File: rtl/hlt_ers_sync.sv
module hlt_ers_sync
    import hlt_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    ers_in,
    output ers_ev_t ev
);

    typedef struct packed {
        logic [STAGES-1:0] sh;
        logic              prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.sh   = {s_q.sh[STAGES-2:0], ers_in};
        s_d.prev = s_q.sh[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    always_comb begin
        ev.lvl  = s_q.sh[STAGES-1];
        ev.rise = s_q.sh[STAGES-1] & ~s_q.prev;
        ev.fall = ~s_q.sh[STAGES-1] & s_q.prev;
    end

    // R3: a rising edge is decoded only after the input was seen low then high
    p_rise_hist_r3: assert property (@(posedge clk) disable iff (rst)
        ev.rise |-> $past(ev.lvl) == 1'b0)
        else $error("p_rise_hist_r3");

endmodule

// File: rtl/hlt_trig_decode.sv
module hlt_trig_decode
    import hlt_pkg::*;
(
    input  ers_ev_t     ev,
    input  logic        en,
    input  logic        inv_pol,
    input  start_mode_e start_mode,
    input  clr_mode_e   clr_mode,
    input  halt_mode_e  halt_mode,
    input  logic        match_q,
    input  logic        run_q,
    output logic        start_evt,
    output logic        stop_evt,
    output logic        cap_evt,
    output logic        hold_clr,
    output logic        cnt_clr
);

    logic act_lvl, act_edge, any_edge;
    logic st_raw, sp_raw;

    always_comb begin
        act_lvl  = ev.lvl ^ inv_pol;
        act_edge = inv_pol ? ev.fall : ev.rise;
        any_edge = ev.rise | ev.fall;

        unique case (start_mode)
            ST_FREE:  st_raw = 1'b1;
            ST_ANY:   st_raw = any_edge;
            ST_EDGE:  st_raw = act_edge;
            default:  st_raw = act_lvl;
        endcase

        unique case (halt_mode)
            HL_NONE:  sp_raw = 1'b0;
            HL_ANY:   sp_raw = any_edge;
            HL_EDGE:  sp_raw = act_edge;
            default:  sp_raw = match_q;
        endcase

        start_evt = en & st_raw;
        stop_evt  = en & sp_raw;

        if (halt_mode == HL_NONE) cap_evt = en & act_edge;
        else                      cap_evt = stop_evt & run_q;

        hold_clr = en & (clr_mode == CL_LVL) & ~act_lvl;
        cnt_clr  = hold_clr
                 | (en & match_q & (clr_mode != CL_NONE))
                 | ((clr_mode == CL_START) & start_evt & ~run_q);
    end

endmodule

// File: rtl/hlt_timer.sv
module hlt_timer
    import hlt_pkg::*;
#(
    parameter int CW     = 16,
    parameter int STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ers_in,
    input  logic          en,
    input  logic          inv_pol,
    input  logic [1:0]    start_sel,
    input  logic [1:0]    clr_sel,
    input  logic [1:0]    halt_sel,
    input  logic [CW-1:0] period,
    output logic [CW-1:0] count,
    output logic          running,
    output logic          lvl_out,
    output logic [CW-1:0] cap_val,
    output logic          cap_stb
);

    localparam logic [CW-1:0] ONE = CW'(1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [CW-1:0] cap;
        logic          run;
        logic          lvl;
        logic          match;
        logic          stb;
    } tmr_t;

    tmr_t    t_d, t_q;
    ers_ev_t ev;
    logic    start_evt, stop_evt, cap_evt, hold_clr, cnt_clr;
    logic    run_nx;

    hlt_ers_sync #(.STAGES(STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .ers_in (ers_in),
        .ev     (ev)
    );

    hlt_trig_decode u_dec (
        .ev         (ev),
        .en         (en),
        .inv_pol    (inv_pol),
        .start_mode (start_mode_e'(start_sel)),
        .clr_mode   (clr_mode_e'(clr_sel)),
        .halt_mode  (halt_mode_e'(halt_sel)),
        .match_q    (t_q.match),
        .run_q      (t_q.run),
        .start_evt  (start_evt),
        .stop_evt   (stop_evt),
        .cap_evt    (cap_evt),
        .hold_clr   (hold_clr),
        .cnt_clr    (cnt_clr)
    );

    always_comb begin
        t_d     = t_q;
        t_d.stb = 1'b0;

        if (cap_evt) begin
            t_d.cap = t_q.cnt;
            t_d.stb = 1'b1;
        end

        if (!en || hold_clr) run_nx = 1'b0;
        else if (t_q.run)    run_nx = ~stop_evt;
        else                 run_nx = start_evt;
        t_d.run = run_nx;
        t_d.lvl = run_nx;

        if (cnt_clr)                          t_d.cnt = '0;
        else if (t_q.run && en && !stop_evt)  t_d.cnt = t_q.cnt + ONE;

        t_d.match = run_nx && (t_d.cnt == period);
    end

    always_ff @(posedge clk) begin
        if (rst) t_q <= '0;
        else     t_q <= t_d;
    end

    assign count   = t_q.cnt;
    assign running = t_q.run;
    assign lvl_out = t_q.lvl;
    assign cap_val = t_q.cap;
    assign cap_stb = t_q.stb;

    // R10: level output mirrors run status
    p_lvl_run_r10: assert property (@(posedge clk) disable iff (rst)
        lvl_out == running)
        else $error("p_lvl_run_r10");

    // R2: disable stops the timer and freezes the count
    p_off_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !en |=> !running && $stable(count))
        else $error("p_off_idle_r2");

    // R6: strobe accompanies a load of the count from the prior cycle
    p_cap_load_r6: assert property (@(posedge clk) disable iff (rst)
        cap_stb |-> cap_val == $past(count))
        else $error("p_cap_load_r6");

    // R4: inactive level with level clear holds the timer idle at zero
    p_hold_clr_r4: assert property (@(posedge clk) disable iff (rst)
        (en && clr_sel == 2'd1 && (ev.lvl == inv_pol)) |=> (!running && count == '0))
        else $error("p_hold_clr_r4");

endmodule

// File: tb/hlt_timer_test.sv
`timescale 1ns/1ps
module hlt_timer_test;

    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst, ers_in, en, inv_pol;
    logic [1:0]    start_sel, clr_sel, halt_sel;
    logic [CW-1:0] period;
    logic [CW-1:0] count, cap_val;
    logic          running, lvl_out, cap_stb;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    hlt_timer #(.CW(CW)) uut (
        .clk(clk), .rst(rst), .ers_in(ers_in), .en(en), .inv_pol(inv_pol),
        .start_sel(start_sel), .clr_sel(clr_sel), .halt_sel(halt_sel),
        .period(period), .count(count), .running(running), .lvl_out(lvl_out),
        .cap_val(cap_val), .cap_stb(cap_stb)
    );

    task automatic adv(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] st, input logic [1:0] cl,
                            input logic [1:0] hl, input logic inv, input int per);
        rst = 1'b1; en = 1'b0; ers_in = 1'b0;
        start_sel = st; clr_sel = cl; halt_sel = hl; inv_pol = inv;
        period = CW'(per);
        adv(2);
        rst = 1'b0;
        adv(1);
    endtask

    task automatic t_reset_r1;
        do_reset(2'd0, 2'd0, 2'd0, 1'b0, 100);
        chk("R1", "count", int'(count), 0);
        chk("R1", "cap_val", int'(cap_val), 0);
        chk("R1", "running", int'(running), 0);
        chk("R1", "cap_stb", int'(cap_stb), 0);
        chk("R1", "lvl_out", int'(lvl_out), 0);
    endtask

    task automatic t_free_r2;
        do_reset(2'd0, 2'd0, 2'd0, 1'b0, 100);
        en = 1'b1;
        adv(1);
        chk("R2", "running after en", int'(running), 1);
        adv(4);
        chk("R2", "count", int'(count), 4);
        en = 1'b0;
        adv(1);
        chk("R2", "running after en low", int'(running), 0);
        adv(3);
        chk("R2", "held count", int'(count), 4);
    endtask

    task automatic t_edge_r3;
        do_reset(2'd2, 2'd0, 2'd0, 1'b1, 100);
        en = 1'b1;
        ers_in = 1'b1;
        adv(5);
        chk("R3", "rising ignored when inverted", int'(running), 0);
        ers_in = 1'b0;
        adv(2);
        chk("R3", "not yet started", int'(running), 0);
        adv(1);
        chk("R3", "started on falling edge", int'(running), 1);
        chk("R10", "lvl_out", int'(lvl_out), 1);
    endtask

    task automatic t_level_r4;
        do_reset(2'd3, 2'd1, 2'd0, 1'b0, 200);
        en = 1'b1;
        adv(3);
        chk("R4", "idle at inactive level", int'(running), 0);
        ers_in = 1'b1;
        adv(3);
        chk("R4", "started by level", int'(running), 1);
        adv(2);
        chk("R4", "count while active", int'(count), 2);
        ers_in = 1'b0;
        adv(2);
        chk("R4", "count before clear", int'(count), 4);
        adv(1);
        chk("R4", "running cleared", int'(running), 0);
        chk("R4", "lvl_out cleared", int'(lvl_out), 0);
        chk("R4", "count cleared", int'(count), 0);
    endtask

    task automatic t_match_clr_r5;
        do_reset(2'd0, 2'd3, 2'd0, 1'b0, 3);
        en = 1'b1;
        for (int k = 1; k <= 10; k++) begin
            adv(1);
            chk("R5", "wrap count", int'(count), (k - 1) % 4);
        end
        chk("R5", "still running", int'(running), 1);
    endtask

    task automatic t_match_stop_r6;
        do_reset(2'd2, 2'd0, 2'd3, 1'b0, 5);
        en = 1'b1;
        ers_in = 1'b1;
        adv(8);
        chk("R6", "running at match", int'(running), 1);
        chk("R6", "count at match", int'(count), 5);
        adv(1);
        chk("R6", "stopped", int'(running), 0);
        chk("R6", "cap_val", int'(cap_val), 5);
        chk("R6", "cap_stb", int'(cap_stb), 1);
        chk("R6", "count held", int'(count), 5);
        adv(1);
        chk("R6", "strobe one cycle", int'(cap_stb), 0);
        chk("R6", "count still held", int'(count), 5);
    endtask

    task automatic t_toggle_r7;
        do_reset(2'd1, 2'd2, 2'd1, 1'b1, 1000);
        en = 1'b1;
        ers_in = 1'b1;
        adv(3);
        chk("R7", "start on rise", int'(running), 1);
        chk("R7", "count at start", int'(count), 0);
        adv(4);
        ers_in = 1'b0;
        adv(3);
        chk("R7", "stop on fall", int'(running), 0);
        chk("R7", "capture on stop", int'(cap_val), 6);
        chk("R7", "strobe on stop", int'(cap_stb), 1);
        chk("R7", "count held", int'(count), 6);
        ers_in = 1'b1;
        adv(3);
        chk("R7", "restart", int'(running), 1);
        chk("R7", "cleared on start", int'(count), 0);
    endtask

    task automatic t_cap_only_r8;
        do_reset(2'd0, 2'd0, 2'd0, 1'b1, 1000);
        ers_in = 1'b1;
        adv(4);
        en = 1'b1;
        adv(4);
        chk("R8", "count before edge", int'(count), 3);
        ers_in = 1'b0;
        adv(3);
        chk("R8", "cap_val", int'(cap_val), 5);
        chk("R8", "cap_stb", int'(cap_stb), 1);
        chk("R8", "keeps running", int'(running), 1);
        chk("R8", "count advanced", int'(count), 6);
    endtask

    task automatic t_collide_r9;
        do_reset(2'd2, 2'd3, 2'd1, 1'b0, 4);
        en = 1'b1;
        ers_in = 1'b1;
        adv(5);
        ers_in = 1'b0;
        adv(2);
        chk("R9", "count at match", int'(count), 4);
        adv(1);
        chk("R9", "captured pre-clear count", int'(cap_val), 4);
        chk("R9", "strobe", int'(cap_stb), 1);
        chk("R9", "count cleared", int'(count), 0);
        chk("R9", "stopped", int'(running), 0);
        chk("R10", "lvl_out follows", int'(lvl_out), 0);
    endtask

    initial begin
        rst = 1'b1; en = 1'b0; ers_in = 1'b0; inv_pol = 1'b0;
        start_sel = '0; clr_sel = '0; halt_sel = '0; period = '0;
        t_reset_r1();
        t_free_r2();
        t_edge_r3();
        t_level_r4();
        t_match_clr_r5();
        t_match_stop_r6();
        t_toggle_r7();
        t_cap_only_r8();
        t_collide_r9();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule